// File: doc/BRIEF.md
# Sixteen-Channel Latched Input/Output Register

This block holds one capture latch for each of sixteen input lines. A latch is set by a rising edge on its line after that line passes through a two-stage synchronizer. Once set, the latch stays set until software clears it. Each channel output is driven from its latch. A per-channel mask can hide the latch, and a per-channel force bit can drive the output high whatever the latch and mask hold.

A single interrupt request line is the registered OR of the set latches whose interrupt-mask bits are zero. A stored three-bit priority value is presented next to the request, and it does not change the request. Software controls the block over a simple synchronous bus that has an address, a write strobe, a read strobe, write data and registered read data. A write of any value to the clear offset empties every latch.

Top module: `lio_chan_reg`

## Requirements
- R1: After a synchronous active-low reset, the force, mask, interrupt-mask and level registers all read 0x0000, every latch is clear, `chan_out` is 0 and `irq_req` is 0.
- R2: A rising edge on `chan_in[i]` sets latch i. The set latch is visible on the third rising clock edge after the input rises. The latch stays set after the input falls.
- R3: A write of any data to offset 0x10 clears every latch at that clock edge. The force, mask, interrupt-mask and level registers keep their values.
- R4: If a synchronized rising edge on channel i arrives in the same cycle as a clear write, latch i ends up set.
- R5: `chan_out[i]` equals force[i] OR (latch[i] AND NOT mask[i]), where force is at offset 0x0A and mask at offset 0x0C, with bit i controlling channel i.
- R6: A mask bit of 1 stops a set latch from driving its output. A force bit of 1 still drives that output high.
- R7: `irq_req` rises one cycle after any latch is set with its interrupt-mask bit (offset 0x0E) at 0. It falls one cycle after the contributing latches are cleared or masked.
- R8: Offsets 0x0A, 0x0C and 0x0E are 16-bit read/write registers. Offset 0x12 holds a 3-bit level in data bits 2:0, which is shown on `irq_level` and reads back zero-extended. Read data is updated at the clock edge that samples `bus_rd` and holds between reads.
- R9: A read of offset 0x10 returns 0x0000. A read of any unmapped offset returns the 16 latch states. Reads never change any state.
- R10: The level value has no effect on `irq_req`. Writes to unmapped offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_in | input | 16 | Asynchronous channel input lines |
| chan_out | output | 16 | Combined channel outputs |
| irq_req | output | 1 | Registered interrupt request level |
| irq_level | output | 3 | Stored interrupt priority value |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
On every cycle, the assertions check the latch rules: a synchronized edge always leaves its latch set, a clear with no edge empties the bank, and a latch never drops without a clear. They also check that a clear write leaves the control registers unchanged, that a read of the clear offset returns zero, and that the request never rises unless some latch was set. The three-cycle input latency, the override order of force over mask, interrupt masking and unmasking, and the result of a clear that meets a new edge can only be shown by the bench's scenarios. In those scenarios a behavioural model is compared with the outputs on every clock.

// File: rtl/lio_pkg.sv
// Package: register offsets shared by the latched I/O register block.
// Assumes byte offsets decoded on a 5-bit address.
package lio_pkg;
    localparam int unsigned LIO_AW   = 5;
    localparam int unsigned LIO_LVLW = 3;
    localparam logic [LIO_AW-1:0] OFS_FORCE = 5'h0A;
    localparam logic [LIO_AW-1:0] OFS_MASK  = 5'h0C;
    localparam logic [LIO_AW-1:0] OFS_IMASK = 5'h0E;
    localparam logic [LIO_AW-1:0] OFS_CLEAR = 5'h10;
    localparam logic [LIO_AW-1:0] OFS_LEVEL = 5'h12;
endpackage

// File: rtl/lio_sync.sv
// Module: per-channel synchronizer and rising-edge detector.
// Assumes asynchronous inputs. STAGES flops then one history flop;
// rise_o is a one-cycle pulse on a synchronized 0->1 transition.
module lio_sync #(
    parameter int unsigned NCH    = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] rise_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [DEPTH-1:0] pipe;

        // Shift the raw input through the synchronizer and history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[DEPTH-2:0], din[i]};
        end

        // Edge is newest synchronized sample high while the previous was low.
        assign rise_o[i] = pipe[STAGES-1] & ~pipe[STAGES];
    end
endmodule

// File: rtl/lio_latch.sv
// Module: bank of capture latches, one per channel.
// Assumes rise_i is a single-cycle pulse; a new edge beats a clear.
module lio_latch #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic [NCH-1:0] rise_i,
    output logic [NCH-1:0] state_o
);
    logic [NCH-1:0] held;

    // Clear the bank on request, then OR in fresh edges so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= '0;
        else        state_o <= held | rise_i;
    end

    // Bits kept from the current state when no clear is requested.
    always_comb begin
        held = clr_i ? '0 : state_o;
    end

    // R2 R4
    latch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_i) |=> ((state_o & $past(rise_i)) == $past(rise_i)));

    // R3
    latch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|rise_i)) |=> (state_o == '0));

    // R2
    latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((state_o & $past(state_o)) == $past(state_o)));
endmodule

// File: rtl/lio_regs.sv
// Module: register file and bus decode for the latched I/O register.
// Assumes single-cycle strobes; read data is registered and held.
module lio_regs
    import lio_pkg::*;
#(
    parameter int unsigned NCH  = 16,
    parameter int unsigned AW   = LIO_AW,
    parameter int unsigned LVLW = LIO_LVLW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic            rd,
    input  logic [NCH-1:0]  wdata,
    input  logic [NCH-1:0]  state_i,
    output logic [NCH-1:0]  rdata,
    output logic [NCH-1:0]  force_o,
    output logic [NCH-1:0]  mask_o,
    output logic [NCH-1:0]  imask_o,
    output logic [LVLW-1:0] level_o,
    output logic            clr_o
);
    logic [NCH-1:0] rd_mux;

    // Decode the clear strobe; data is ignored.
    always_comb begin
        clr_o = wr && (addr == OFS_CLEAR);
    end

    // Update the control registers on writes to their offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_o <= '0;
            mask_o  <= '0;
            imask_o <= '0;
            level_o <= '0;
        end else if (wr) begin
            case (addr)
                OFS_FORCE: force_o <= wdata;
                OFS_MASK:  mask_o  <= wdata;
                OFS_IMASK: imask_o <= wdata;
                OFS_LEVEL: level_o <= wdata[LVLW-1:0];
                default:   ;
            endcase
        end
    end

    // Select the value returned for the addressed offset.
    always_comb begin
        case (addr)
            OFS_FORCE: rd_mux = force_o;
            OFS_MASK:  rd_mux = mask_o;
            OFS_IMASK: rd_mux = imask_o;
            OFS_LEVEL: rd_mux = {{(NCH-LVLW){1'b0}}, level_o};
            OFS_CLEAR: rd_mux = '0;
            default:   rd_mux = state_i;
        endcase
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    // R3
    clear_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> ($stable(force_o) && $stable(mask_o) && $stable(imask_o) && $stable(level_o)));

    // R9
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == OFS_CLEAR) |=> (rdata == '0));
endmodule

// File: rtl/lio_chan_reg.sv
// Module: sixteen-channel latched I/O register, top level.
// Combines latches with force and mask bits into outputs and raises a
// registered interrupt request from unmasked set latches.
module lio_chan_reg
    import lio_pkg::*;
#(
    parameter int unsigned NCH    = 16,
    parameter int unsigned AW     = LIO_AW,
    parameter int unsigned LVLW   = LIO_LVLW,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  chan_in,
    output logic [NCH-1:0]  chan_out,
    output logic            irq_req,
    output logic [LVLW-1:0] irq_level,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [NCH-1:0]  bus_wdata,
    output logic [NCH-1:0]  bus_rdata
);
    logic [NCH-1:0] rise, latch_q, force_q, mask_q, imask_q;
    logic           clr;

    lio_sync #(.NCH(NCH), .STAGES(STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(chan_in), .rise_o(rise)
    );

    lio_latch #(.NCH(NCH)) i_latch (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .rise_i(rise), .state_o(latch_q)
    );

    lio_regs #(.NCH(NCH), .AW(AW), .LVLW(LVLW)) i_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .state_i(latch_q), .rdata(bus_rdata),
        .force_o(force_q), .mask_o(mask_q), .imask_o(imask_q),
        .level_o(irq_level), .clr_o(clr)
    );

    // Force wins over everything; mask only hides the latch.
    always_comb begin
        chan_out = force_q | (latch_q & ~mask_q);
    end

    // Register the OR of set latches that are not interrupt-masked.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= |(latch_q & ~imask_q);
    end

    // R7
    irq_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(|latch_q));
endmodule

// File: tb/test_lio_chan_reg.sv
`timescale 1ns/1ps
module test_lio_chan_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] chan_in = '0;
    logic [15:0] chan_out;
    logic        irq_req;
    logic [2:0]  irq_level;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int compared = 0;
    int mismatched = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lio_chan_reg i_lio_chan_reg (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .chan_out(chan_out),
        .irq_req(irq_req), .irq_level(irq_level), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Behavioural reference model
    logic [15:0] hist[$];
    logic [15:0] m_lat, m_frc, m_msk, m_imsk, m_rd;
    logic [2:0]  m_lvl;
    logic        m_irq;

    initial begin
        hist = '{16'h0, 16'h0, 16'h0};
        m_lat = 0; m_frc = 0; m_msk = 0; m_imsk = 0; m_rd = 0; m_lvl = 0; m_irq = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{16'h0, 16'h0, 16'h0};
            m_lat = 0; m_frc = 0; m_msk = 0; m_imsk = 0; m_rd = 0; m_lvl = 0; m_irq = 0;
        end else begin
            logic [15:0] edges;
            logic [15:0] old_lat;
            edges = hist[1] & ~hist[2];
            old_lat = m_lat;
            m_irq = |(m_lat & ~m_imsk);
            if (bus_rd) begin
                if (bus_addr == 5'h0A) m_rd = m_frc;
                else if (bus_addr == 5'h0C) m_rd = m_msk;
                else if (bus_addr == 5'h0E) m_rd = m_imsk;
                else if (bus_addr == 5'h12) m_rd = {13'h0, m_lvl};
                else if (bus_addr == 5'h10) m_rd = 16'h0;
                else m_rd = old_lat;
            end
            if (bus_wr && bus_addr == 5'h10) m_lat = 16'h0;
            m_lat = m_lat | edges;
            if (bus_wr) begin
                if (bus_addr == 5'h0A) m_frc = bus_wdata;
                else if (bus_addr == 5'h0C) m_msk = bus_wdata;
                else if (bus_addr == 5'h0E) m_imsk = bus_wdata;
                else if (bus_addr == 5'h12) m_lvl = bus_wdata[2:0];
            end
            hist.push_front(chan_in);
            void'(hist.pop_back());
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R5 chan_out", chan_out, m_frc | (m_lat & ~m_msk));
            check("R7 irq_req", {15'h0, irq_req}, {15'h0, m_irq});
            check("R8 irq_level", {13'h0, irq_level}, {13'h0, m_lvl});
            check("R9 bus_rdata", bus_rdata, m_rd);
        end
    end

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] lf;
        logic [4:0]  alist[6];
        alist = '{5'h0A, 5'h0C, 5'h0E, 5'h10, 5'h12, 5'h00};
        tick(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tick();
        // R1 reset state
        check("R1 chan_out", chan_out, 16'h0);
        check("R1 irq_req", {15'h0, irq_req}, 16'h0);
        rd(5'h0A, v); check("R1 force", v, 16'h0);
        rd(5'h0E, v); check("R1 imask", v, 16'h0);
        rd(5'h12, v); check("R1 level", v, 16'h0);

        // R2 latency and hold
        chan_in = 16'h0005;
        tick(2);
        check("R2 not yet latched", chan_out, 16'h0000);
        tick();
        check("R2 latched", chan_out, 16'h0005);
        chan_in = 16'h0000;
        tick();
        check("R7 irq raised", {15'h0, irq_req}, 16'h1);
        rd(5'h00, v); check("R2 held after input fell", v, 16'h0005);

        // R7 masking drops request
        wr(5'h0E, 16'hFFFF);
        tick();
        check("R7 irq masked", {15'h0, irq_req}, 16'h0);
        wr(5'h0E, 16'h0000);
        tick();
        check("R7 irq unmasked", {15'h0, irq_req}, 16'h1);

        // R5 R6 force and mask
        wr(5'h0C, 16'h0001);
        check("R6 mask hides", chan_out, 16'h0004);
        wr(5'h0A, 16'h0100);
        check("R5 force adds", chan_out, 16'h0104);
        wr(5'h0A, 16'h0001);
        check("R6 force beats mask", chan_out, 16'h0005);
        wr(5'h0A, 16'h0000);
        wr(5'h0C, 16'h0000);

        // R3 R4 clear meets new edge
        wr(5'h0E, 16'h00F0);
        chan_in = 16'h0008;
        tick(2);
        wr(5'h10, 16'hBEEF);
        rd(5'h00, v); check("R4 edge wins clear", v, 16'h0008);
        rd(5'h0E, v); check("R3 imask kept", v, 16'h00F0);
        check("R3 others cleared", chan_out, 16'h0008);
        chan_in = 16'h0000;

        // R9 reads
        rd(5'h10, v); check("R9 clear reads zero", v, 16'h0000);
        rd(5'h1E, v); check("R9 unmapped reads latches", v, 16'h0008);
        rd(5'h1E, v); check("R9 read no side effect", v, 16'h0008);

        // R8 R10 level and unmapped writes
        wr(5'h12, 16'hFFF5);
        check("R8 level out", {13'h0, irq_level}, 16'h0005);
        rd(5'h12, v); check("R8 level readback", v, 16'h0005);
        check("R10 level no effect", {15'h0, irq_req}, 16'h1);
        wr(5'h04, 16'hFFFF);
        check("R10 unmapped write", chan_out, 16'h0008);
        rd(5'h0A, v); check("R10 force unchanged", v, 16'h0000);
        rd(5'h0C, v); check("R10 mask unchanged", v, 16'h0000);

        // Mixed traffic compared against the model
        lf = 16'hACE1;
        for (int c = 0; c < 600; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            chan_in = lf;
            bus_addr = alist[c % 6];
            bus_wdata = {lf[7:0], lf[15:8]};
            bus_wr = (c % 7 == 3);
            bus_rd = (c % 5 == 1);
            tick();
        end
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        tick(4);
        finish_run();
    end
endmodule